// File: doc/BRIEF.md
# Two-Stream Delay Commutator for a Pipelined Radix-2 FFT

This block sits between two butterfly stages of a pipelined radix-2 decimation-in-frequency FFT that has one butterfly unit per stage. The previous stage delivers two parallel complex sample streams, each carrying sub-sequences of length 2n. The next butterfly must see element i next to element i+n of the same sub-sequence. The block reorders the streams with two delay lines of n samples and a commutator switch. A phase counter flips the switch every n valid samples, so the upper and lower paths see unequal total delays.

On each output cycle the two outputs carry two samples whose sub-sequence indices differ by exactly n. During one half-period the pairs come from the upper input stream. During the other half-period they come from the lower input stream. For the first stage of a pipeline, a parameter adds a front end. It buffers the first half of each serial block of 4n samples and then emits that half on the upper path while the second half arrives on the lower path. The commutator then takes that half-rate pair of streams.

Each complex sample is packed as {imaginary, real}, with each part SAMPLE_W bits wide. The block moves samples without changing them.

Top module: `reorder_commutator`

## Requirements
- R1: While rstSync is high, outValid, outUpper and outLower are all zero on the following clock edge.
- R2: After reset, the first HALF_LEN valid input samples give no outValid. Every later valid input gives outValid high one clock after it is accepted.
- R3: Count valid samples t from 0 after reset. When t mod 2·HALF_LEN is at least HALF_LEN (crossed phase), the registered output is outUpper = upper input of step t−HALF_LEN and outLower = upper input of step t.
- R4: When t mod 2·HALF_LEN is below HALF_LEN and t ≥ 2·HALF_LEN (straight phase), outUpper = lower input of step t−2·HALF_LEN and outLower = lower input of step t−HALF_LEN.
- R5: In every valid output pair, the source index of outLower exceeds the source index of outUpper by exactly HALF_LEN, and both samples come from the same stream.
- R6: A cycle with inValid low changes no state. outValid is low on the next cycle, both data outputs hold their values, and the phase and delay contents are unchanged.
- R7: A synchronous reset asserted mid-stream restarts the phase count and the fill count, so the pattern of R2 to R4 starts again from t = 0.
- R8: With FRONT_SPLIT = 1, inUpper carries one serial stream in blocks of 4·HALF_LEN samples and inLower is ignored. Samples in the first half of a block give no outValid. Each sample j of the second half is paired with sample j−2·HALF_LEN, which feeds the upper path.
- R9: With FRONT_SPLIT = 1, the outputs pair serial indices (i, i+HALF_LEN) for i below HALF_LEN, and then (2·HALF_LEN+i, 3·HALF_LEN+i), in each block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstSync | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input samples present this cycle |
| inUpper | input | 2·SAMPLE_W | Upper input stream, or the serial stream when FRONT_SPLIT = 1 |
| inLower | input | 2·SAMPLE_W | Lower input stream (unused when FRONT_SPLIT = 1) |
| outValid | output | 1 | Output pair is valid |
| outUpper | output | 2·SAMPLE_W | First element of the butterfly pair |
| outLower | output | 2·SAMPLE_W | Element HALF_LEN positions later |

## Verification
Every result is due exactly one clock after the valid input that produces it. The bench drives each sample half a period before a rising edge and reads the outputs at the next falling edge. The expected value at valid step t comes from a history of the samples the bench sent: it looks back HALF_LEN steps, or 2·HALF_LEN steps in the straight phase. Idle cycles do not advance t, so each check looks at the cycle right after the idle input and compares the outputs with the values held from before it. After a reset, the bench restarts its own step count to match the restarted phase.

// File: rtl/reorder_pkg.sv
package reorder_pkg;
  typedef struct packed {
    logic advance;
    logic crossed;
    logic fillDone;
  } commStrobe_t;
endpackage

// File: rtl/reorder_delay.sv
module reorder_delay #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             shiftEn,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);
  logic [WIDTH-1:0] stageReg [DEPTH];

  always_ff @(posedge clk) begin
    if (shiftEn) begin
      stageReg[0] <= dataIn;
      for (int i = 1; i < DEPTH; i++) stageReg[i] <= stageReg[i-1];
    end
  end

  assign dataOut = stageReg[DEPTH-1];
endmodule

// File: rtl/reorder_ctrl.sv
module reorder_ctrl
  import reorder_pkg::*;
#(
  parameter int HALF_LEN = 4
) (
  input  logic        clk,
  input  logic        rstSync,
  input  logic        inValid,
  output commStrobe_t strobe
);
  localparam int CNT_W = (HALF_LEN > 1) ? $clog2(HALF_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_LEN - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic             crossed;
  logic             fillDone;
  logic             wrap;

  assign wrap = inValid && (phaseCnt == LAST);

  always_ff @(posedge clk) begin
    if (rstSync) begin
      phaseCnt <= '0;
      crossed  <= 1'b0;
      fillDone <= 1'b0;
    end else if (inValid) begin
      phaseCnt <= wrap ? '0 : phaseCnt + 1'b1;
      if (wrap) begin
        crossed  <= ~crossed;
        fillDone <= 1'b1;
      end
    end
  end

  assign strobe.advance  = inValid;
  assign strobe.crossed  = crossed;
  assign strobe.fillDone = fillDone;

  p_wrap_toggle_r3: assert property (@(posedge clk) disable iff (rstSync)
    wrap |=> (crossed != $past(crossed)));
  p_idle_phase_r6: assert property (@(posedge clk) disable iff (rstSync)
    !inValid |=> ($stable(crossed) && $stable(phaseCnt)));
  p_fill_sticky_r2: assert property (@(posedge clk) disable iff (rstSync)
    fillDone |=> fillDone);
endmodule

// File: rtl/reorder_datapath.sv
module reorder_datapath
  import reorder_pkg::*;
#(
  parameter int HALF_LEN = 4,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstSync,
  input  commStrobe_t       strobe,
  input  logic [DATA_W-1:0] upperIn,
  input  logic [DATA_W-1:0] lowerIn,
  output logic              pairValid,
  output logic [DATA_W-1:0] pairUpper,
  output logic [DATA_W-1:0] pairLower
);
  logic [DATA_W-1:0] lowerTail;
  logic [DATA_W-1:0] topPath;
  logic [DATA_W-1:0] topTail;

  reorder_delay #(.DEPTH(HALF_LEN), .WIDTH(DATA_W)) uLowerDly (
    .clk(clk), .shiftEn(strobe.advance), .dataIn(lowerIn), .dataOut(lowerTail));

  assign topPath = strobe.crossed ? lowerTail : upperIn;

  reorder_delay #(.DEPTH(HALF_LEN), .WIDTH(DATA_W)) uTopDly (
    .clk(clk), .shiftEn(strobe.advance), .dataIn(topPath), .dataOut(topTail));

  always_ff @(posedge clk) begin
    if (rstSync) begin
      pairValid <= 1'b0;
      pairUpper <= '0;
      pairLower <= '0;
    end else begin
      pairValid <= strobe.advance && strobe.fillDone;
      if (strobe.advance) begin
        pairUpper <= topTail;
        pairLower <= strobe.crossed ? upperIn : lowerTail;
      end
    end
  end

  p_cross_route_r3: assert property (@(posedge clk) disable iff (rstSync)
    (strobe.advance && strobe.crossed) |=> (pairLower == $past(upperIn)));
  p_no_valid_unfilled_r2: assert property (@(posedge clk) disable iff (rstSync)
    (strobe.advance && !strobe.fillDone) |=> !pairValid);
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rstSync)
    !strobe.advance |=> (!pairValid && $stable(pairUpper) && $stable(pairLower)));
endmodule

// File: rtl/reorder_split_front.sv
module reorder_split_front
  import reorder_pkg::*;
#(
  parameter int HALF_LEN = 4,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstSync,
  input  logic              serValid,
  input  logic [DATA_W-1:0] serData,
  output logic              splitValid,
  output logic [DATA_W-1:0] splitUpper,
  output logic [DATA_W-1:0] splitLower
);
  localparam int BUF_LEN = 2 * HALF_LEN;

  commStrobe_t halfStrobe;

  reorder_ctrl #(.HALF_LEN(BUF_LEN)) uHalf (
    .clk(clk), .rstSync(rstSync), .inValid(serValid), .strobe(halfStrobe));

  reorder_delay #(.DEPTH(BUF_LEN), .WIDTH(DATA_W)) uFifo (
    .clk(clk), .shiftEn(serValid), .dataIn(serData), .dataOut(splitUpper));

  assign splitLower = serData;
  assign splitValid = serValid && halfStrobe.crossed;

  p_half_stable_r8: assert property (@(posedge clk) disable iff (rstSync)
    !serValid |=> $stable(halfStrobe.crossed));
endmodule

// File: rtl/reorder_commutator.sv
module reorder_commutator
  import reorder_pkg::*;
#(
  parameter int HALF_LEN    = 4,
  parameter int SAMPLE_W    = 8,
  parameter bit FRONT_SPLIT = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstSync,
  input  logic                  inValid,
  input  logic [2*SAMPLE_W-1:0] inUpper,
  input  logic [2*SAMPLE_W-1:0] inLower,
  output logic                  outValid,
  output logic [2*SAMPLE_W-1:0] outUpper,
  output logic [2*SAMPLE_W-1:0] outLower
);
  localparam int DATA_W = 2 * SAMPLE_W;

  logic              commValid;
  logic [DATA_W-1:0] commUpper;
  logic [DATA_W-1:0] commLower;
  commStrobe_t       strobe;

  generate
    if (FRONT_SPLIT) begin : gSplit
      reorder_split_front #(.HALF_LEN(HALF_LEN), .DATA_W(DATA_W)) uFront (
        .clk(clk), .rstSync(rstSync), .serValid(inValid), .serData(inUpper),
        .splitValid(commValid), .splitUpper(commUpper), .splitLower(commLower));
    end else begin : gDirect
      assign commValid = inValid;
      assign commUpper = inUpper;
      assign commLower = inLower;
    end
  endgenerate

  reorder_ctrl #(.HALF_LEN(HALF_LEN)) uCtrl (
    .clk(clk), .rstSync(rstSync), .inValid(commValid), .strobe(strobe));

  reorder_datapath #(.HALF_LEN(HALF_LEN), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstSync(rstSync), .strobe(strobe),
    .upperIn(commUpper), .lowerIn(commLower),
    .pairValid(outValid), .pairUpper(outUpper), .pairLower(outLower));

  p_reset_clears_r1: assert property (@(posedge clk)
    rstSync |=> (!outValid && outUpper == '0 && outLower == '0));
endmodule

// File: tb/sim_reorder_commutator.sv
`timescale 1ns/1ps
module sim_reorder_commutator;
  localparam int N = 4;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rstSync = 1'b1;
  logic vA = 1'b0, vB = 1'b0;
  logic [15:0] upA = '0, loA = '0, serB = '0;
  logic oValA, oValB;
  logic [15:0] oUpA, oLoA, oUpB, oLoB;

  always #2.5 clk = ~clk;

  reorder_commutator #(.HALF_LEN(N), .SAMPLE_W(SW), .FRONT_SPLIT(1'b0)) u0 (
    .clk(clk), .rstSync(rstSync), .inValid(vA), .inUpper(upA), .inLower(loA),
    .outValid(oValA), .outUpper(oUpA), .outLower(oLoA));

  reorder_commutator #(.HALF_LEN(N), .SAMPLE_W(SW), .FRONT_SPLIT(1'b1)) u1 (
    .clk(clk), .rstSync(rstSync), .inValid(vB), .inUpper(serB), .inLower(16'hFFFF),
    .outValid(oValB), .outUpper(oUpB), .outLower(oLoB));

  int checks = 0, fails = 0;
  bit finished = 0;
  int tA = 0;
  logic [15:0] uHist [256];
  logic [15:0] vHist [256];
  int cB = 0, jB = 0;
  logic [15:0] cuHist [256];
  logic [15:0] cvHist [256];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model of R3/R4 for a commutator input history
  task automatic expectPair(input string req, input int t, input logic [15:0] act1,
                            input logic [15:0] act2, input bit useB);
    logic [15:0] e1, e2;
    if (((t / N) % 2) == 1) begin
      e1 = useB ? cuHist[t-N] : uHist[t-N];
      e2 = useB ? cuHist[t]   : uHist[t];
    end else begin
      e1 = useB ? cvHist[t-2*N] : vHist[t-2*N];
      e2 = useB ? cvHist[t-N]   : vHist[t-N];
    end
    chk({req, " upper"}, {16'h0, act1}, {16'h0, e1});
    chk({req, " lower"}, {16'h0, act2}, {16'h0, e2});
  endtask

  task automatic stepA(input bit valid);
    logic [15:0] prevUp, prevLo;
    prevUp = oUpA; prevLo = oLoA;
    vA = valid;
    upA = {8'h11, 8'(tA)};
    loA = {8'h22, 8'(tA)};
    if (valid) begin uHist[tA] = upA; vHist[tA] = loA; end
    @(negedge clk);
    if (!valid) begin
      chk("R6 idle valid", {31'h0, oValA}, 32'h0);
      chk("R6 idle hold", {oUpA, oLoA}, {prevUp, prevLo});
    end else begin
      if (tA < N) chk("R2 unfilled", {31'h0, oValA}, 32'h0);
      else begin
        chk("R2 valid", {31'h0, oValA}, 32'h1);
        expectPair(((tA / N) % 2) == 1 ? "R3 crossed" : "R4 straight", tA, oUpA, oLoA, 1'b0);
        chk("R5 index gap", {24'h0, 8'(oLoA[7:0] - oUpA[7:0])}, N);
        chk("R5 same stream", {24'h0, oLoA[15:8]}, {24'h0, oUpA[15:8]});
      end
      tA++;
    end
    vA = 1'b0;
  endtask

  task automatic doReset;
    rstSync = 1'b1; vA = 1'b0; vB = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 reset valid A", {30'h0, oValA, oValB}, 32'h0);
    chk("R1 reset data A", {oUpA, oLoA}, 32'h0);
    chk("R1 reset data B", {oUpB, oLoB}, 32'h0);
    rstSync = 1'b0;
    tA = 0; cB = 0; jB = 0;
  endtask

  task automatic testStream;
    for (int k = 0; k < 6 * N; k++) stepA(1'b1);
  endtask

  task automatic testGaps;
    for (int k = 0; k < 4 * N; k++) begin
      stepA(1'b1);
      if (k % 3 == 1) stepA(1'b0);
    end
  endtask

  task automatic testMidReset;
    for (int k = 0; k < N + 2; k++) stepA(1'b1);
    rstSync = 1'b1;
    @(negedge clk);
    chk("R7 reset mid-stream", {31'h0, oValA}, 32'h0);
    rstSync = 1'b0;
    tA = 0; cB = 0; jB = 0;
    for (int k = 0; k < 3 * N; k++) stepA(1'b1);
  endtask

  task automatic testSplit;
    for (int k = 0; k < 12 * N; k++) begin
      int pos;
      bit second;
      int blk;
      pos = jB % (4 * N);
      second = (pos >= 2 * N);
      blk = jB - pos;
      vB = 1'b1;
      serB = {8'h33, 8'(jB)};
      if (second) begin
        cuHist[cB] = {8'h33, 8'(jB - 2 * N)};
        cvHist[cB] = serB;
      end
      @(negedge clk);
      if (!second || cB < N) chk("R8 first half quiet", {31'h0, oValB}, 32'h0);
      else begin
        chk("R8 valid", {31'h0, oValB}, 32'h1);
        expectPair("R9 split pair", cB, oUpB, oLoB, 1'b1);
        chk("R9 index gap", {24'h0, 8'(oLoB[7:0] - oUpB[7:0])}, N);
        chk("R9 same block", {31'h0, (int'(oUpB[7:0]) >= blk - 4 * N)}, 32'h1);
      end
      if (second) cB++;
      jB++;
    end
    vB = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    doReset();
    testStream();
    doReset();
    testGaps();
    doReset();
    testMidReset();
    doReset();
    testSplit();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule